// File: doc/BRIEF.md
# Transmit Byte Queue with Threshold Flags

This block is a byte-wide, 64-entry first-in first-out store that sits between a host write path and a packet transmitter. The host pushes bytes in bursts with a write strobe. The transmitter pulls them with a read strobe and gets each byte one cycle later. The block reports its occupancy. It raises a registered almost-full flag and a registered almost-empty flag against two 6-bit programmable thresholds.

Overflow and underflow are latched as separate sticky bits and are also merged into one error flag. These bits are cleared only by a flush. A flush is requested by a two-step sequence on the clear control: the control is held at 1 and then returned to 0. A small sequencer with the states CLS_OPEN and CLS_ARMED watches for that release. The transition CLS_OPEN to CLS_ARMED happens when the clear control is seen high. The transition CLS_ARMED to CLS_OPEN happens when it is seen low, and that edge flushes the queue.

A second machine drives the automatic-transmit request. It has the states TXS_IDLE and TXS_SEND. The transition TXS_IDLE to TXS_SEND happens when auto mode is on and almost-full is high. The transition TXS_SEND to TXS_IDLE happens when the queue is seen empty or a flush occurs.

Top module: `txq_top`

## Requirements
- R1: Reset clears the queue. After reset the level is 0, almost-empty is 1, almost-full, the error bits and the transmit request are 0, and the almost-full and almost-empty thresholds are 0x37 and 0x04.
- R2: Bytes leave in the order they were written. The level port counts stored bytes from 0 to 64. A byte read on one clock edge is on rd_data after that edge and is held until the next read.
- R3: A write while the level is 64 and no byte is read is dropped, and it sets the sticky overflow bit.
- R4: A read while the level is 0 sets the sticky underflow bit and puts 0x00 on rd_data.
- R5: err_flag is the OR of overflow and underflow. All three stay set until a flush.
- R6: A read and a write in the same cycle on a non-empty queue, including a full one, both take effect and the level is unchanged. On an empty queue the write is stored, the read underflows and the level becomes 1.
- R7: Almost-full is set after any edge where the new level is above the almost-full threshold.
- R8: Once set, almost-full clears only on an edge that reads a byte and leaves the level at or below the threshold, or on a flush. Raising the threshold alone does not clear it.
- R9: Almost-empty is 1 exactly when the new level is at or below the almost-empty threshold.
- R10: A thr_load pulse captures both threshold inputs. The flags computed on that same edge already use the new values.
- R11: Holding clr_ctl at 1 has no effect. The edge that first samples it back at 0 empties the queue and clears almost-full, the error bits and the transmit request. Any strobes on that edge are ignored.
- R12: With auto_en high, tx_req rises one edge after almost-full is seen high. It falls one edge after the level is seen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| af_thr_in | input | 6 | Almost-full threshold value to load |
| ae_thr_in | input | 6 | Almost-empty threshold value to load |
| thr_load | input | 1 | Load both thresholds |
| clr_ctl | input | 1 | Clear control; a 1-then-0 sequence flushes |
| auto_en | input | 1 | Enable automatic transmit request |
| level | output | 7 | Stored byte count |
| almost_full | output | 1 | Almost-full flag |
| almost_empty | output | 1 | Almost-empty flag |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| err_flag | output | 1 | Overflow or underflow |
| tx_req | output | 1 | Automatic transmit request |

## Verification
Every internal fault here reaches a port within one or two edges. A wrong occupancy count appears on the level port right after the edge that caused it. A pointer slip shows as a wrong byte on rd_data at the next read. A flag that latches or clears on the wrong edge diverges from a behavioural queue model on that same cycle. A wrong transition in the request machine shows on tx_req one edge after almost-full or an empty level is observed. A clear sequencer that fires early or late leaves a level or error bit that the model does not predict.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int          TXQ_DW     = 8;
    localparam int          TXQ_DEPTH  = 64;
    localparam int          TXQ_TW     = 6;
    localparam logic [5:0]  TXQ_AF_RST = 6'h37;
    localparam logic [5:0]  TXQ_AE_RST = 6'h04;

    typedef enum logic {TXS_IDLE, TXS_SEND} txs_t;
    typedef enum logic {CLS_OPEN, CLS_ARMED} cls_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int CW    = 7,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_ok,
    input  logic          rd_ok,
    input  logic          rd_zero,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_nxt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        if (flush) level_nxt = '0;
        else       level_nxt = level + CW'(wr_ok) - CW'(rd_ok);
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            rd_data <= '0;
        end else begin
            level <= level_nxt;
            if (flush) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (wr_ok) wptr <= step_ptr(wptr);
                if (rd_ok) begin
                    rptr    <= step_ptr(rptr);
                    rd_data <= mem[rptr];
                end else if (rd_zero) begin
                    rd_data <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
    parameter int          TW     = 6,
    parameter int          CW     = 7,
    parameter logic [TW-1:0] AF_RST = 6'h37,
    parameter logic [TW-1:0] AE_RST = 6'h04
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          thr_load,
    input  logic [TW-1:0] af_thr_in,
    input  logic [TW-1:0] ae_thr_in,
    input  logic [CW-1:0] level_nxt,
    input  logic          rd_ok,
    input  logic          ovf_evt,
    input  logic          unf_evt,
    output logic          af,
    output logic          ae,
    output logic          ovf,
    output logic          unf
);
    logic [TW-1:0] af_thr, ae_thr, af_thr_nxt, ae_thr_nxt;
    logic          above_af, above_ae;

    always_comb begin
        af_thr_nxt = thr_load ? af_thr_in : af_thr;
        ae_thr_nxt = thr_load ? ae_thr_in : ae_thr;
        above_af   = level_nxt > CW'(af_thr_nxt);
        above_ae   = level_nxt > CW'(ae_thr_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_thr <= AF_RST;
            ae_thr <= AE_RST;
            af     <= 1'b0;
            ae     <= 1'b1;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            af_thr <= af_thr_nxt;
            ae_thr <= ae_thr_nxt;
            ae     <= !above_ae;
            if (flush) begin
                af  <= 1'b0;
                ovf <= 1'b0;
                unf <= 1'b0;
            end else begin
                if (!af && above_af)             af <= 1'b1;
                else if (af && rd_ok && !above_af) af <= 1'b0;
                if (ovf_evt) ovf <= 1'b1;
                if (unf_evt) unf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_ctl,
    input  logic auto_en,
    input  logic af,
    input  logic level_zero,
    output logic flush,
    output logic tx_req
);
    cls_t cls_q, cls_d;
    txs_t txs_q, txs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= CLS_OPEN;
            txs_q <= TXS_IDLE;
        end else begin
            cls_q <= cls_d;
            txs_q <= txs_d;
        end
    end

    always_comb begin
        cls_d = cls_q;
        unique case (cls_q)
            CLS_OPEN:  if (clr_ctl)  cls_d = CLS_ARMED;
            CLS_ARMED: if (!clr_ctl) cls_d = CLS_OPEN;
        endcase
        txs_d = txs_q;
        if (flush) begin
            txs_d = TXS_IDLE;
        end else begin
            unique case (txs_q)
                TXS_IDLE: if (auto_en && af) txs_d = TXS_SEND;
                TXS_SEND: if (level_zero)    txs_d = TXS_IDLE;
            endcase
        end
    end

    always_comb begin
        flush  = (cls_q == CLS_ARMED) && !clr_ctl;
        tx_req = (txs_q == TXS_SEND);
    end
endmodule

// File: rtl/txq_top.sv
module txq_top
    import txq_pkg::*;
#(
    parameter int            DW     = TXQ_DW,
    parameter int            DEPTH  = TXQ_DEPTH,
    parameter int            TW     = TXQ_TW,
    parameter logic [TW-1:0] AF_RST = TXQ_AF_RST,
    parameter logic [TW-1:0] AE_RST = TXQ_AE_RST,
    localparam int           CW     = $clog2(DEPTH + 1),
    localparam int           AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [TW-1:0] af_thr_in,
    input  logic [TW-1:0] ae_thr_in,
    input  logic          thr_load,
    input  logic          clr_ctl,
    input  logic          auto_en,
    output logic [CW-1:0] level,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          err_flag,
    output logic          tx_req
);
    logic          flush_w, wr_ok, rd_ok, ovf_evt, unf_evt, is_empty, is_full;
    logic [CW-1:0] level_nxt;

    always_comb begin
        is_empty = (level == '0);
        is_full  = (level == CW'(DEPTH));
        rd_ok    = rd_en && !flush_w && !is_empty;
        wr_ok    = wr_en && !flush_w && (!is_full || rd_ok);
        ovf_evt  = wr_en && !flush_w && !wr_ok;
        unf_evt  = rd_en && !flush_w && is_empty;
        err_flag = ovf_flag || unf_flag;
    end

    txq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush_w),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_zero(unf_evt),
        .wr_data(wr_data), .rd_data(rd_data),
        .level(level), .level_nxt(level_nxt)
    );

    txq_flags #(.TW(TW), .CW(CW), .AF_RST(AF_RST), .AE_RST(AE_RST)) u_flags (
        .clk(clk), .rst_n(rst_n), .flush(flush_w),
        .thr_load(thr_load), .af_thr_in(af_thr_in), .ae_thr_in(ae_thr_in),
        .level_nxt(level_nxt), .rd_ok(rd_ok),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt),
        .af(almost_full), .ae(almost_empty), .ovf(ovf_flag), .unf(unf_flag)
    );

    txq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_ctl(clr_ctl), .auto_en(auto_en),
        .af(almost_full), .level_zero(is_empty),
        .flush(flush_w), .tx_req(tx_req)
    );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          flush,
    input logic [CW-1:0] level,
    input logic [7:0]    rd_data,
    input logic          af,
    input logic          ovf,
    input logic          unf,
    input logic          err,
    input logic          tx_req
);
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH) && wr_en && !rd_en && !flush) |=> (ovf && level == CW'(DEPTH)));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_en && !flush) |=> (unf && rd_data == 8'h00));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !flush) |=> err);

    p_pair_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && level != '0 && !flush) |=> $stable(level));

    p_af_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(af) |-> ($past(rd_en) || $past(flush)));

    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !err && !af && !tx_req));

    p_tx_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |-> ($past(level) == '0 || $past(flush)));
endmodule

bind txq_top txq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .flush(flush_w),
    .level(level), .rd_data(rd_data), .af(almost_full), .ovf(ovf_flag),
    .unf(unf_flag), .err(err_flag), .tx_req(tx_req)
);

// File: tb/sim_txq_top.sv
module sim_txq_top;
    localparam int CLK_PER = 10;
    localparam int DEPTH   = 64;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, thr_load = 1'b0, clr_ctl = 1'b0, auto_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [5:0] af_thr_in = '0, ae_thr_in = '0;
    logic [7:0] rd_data;
    logic [6:0] level;
    logic       almost_full, almost_empty, ovf_flag, unf_flag, err_flag, tx_req;

    int n_chk = 0, n_bad = 0;

    txq_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .af_thr_in(af_thr_in), .ae_thr_in(ae_thr_in),
        .thr_load(thr_load), .clr_ctl(clr_ctl), .auto_en(auto_en), .level(level),
        .almost_full(almost_full), .almost_empty(almost_empty), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .err_flag(err_flag), .tx_req(tx_req)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] mq[$];
    logic [7:0] m_rd = '0;
    bit m_af = 0, m_ae = 1, m_ovf = 0, m_unf = 0, m_tx = 0, m_arm = 0, m_live = 0;
    int m_afthr = 'h37, m_aethr = 'h04;

    always @(posedge clk) begin : model
        int  old;
        bit  did, fl;
        if (!rst_n) begin
            mq.delete();
            m_rd = '0; m_af = 0; m_ae = 1; m_ovf = 0; m_unf = 0; m_tx = 0; m_arm = 0;
            m_afthr = 'h37; m_aethr = 'h04; m_live = 0;
        end else begin
            m_live = 1;
            fl    = m_arm && !clr_ctl;
            m_arm = clr_ctl;
            if (thr_load) begin
                m_afthr = int'(af_thr_in);
                m_aethr = int'(ae_thr_in);
            end
            if (fl) begin
                mq.delete();
                m_af = 0; m_ovf = 0; m_unf = 0; m_tx = 0;
            end else begin
                old = mq.size();
                did = 0;
                if (!m_tx && auto_en && m_af) m_tx = 1;
                else if (m_tx && old == 0)    m_tx = 0;
                if (rd_en) begin
                    if (old > 0) begin m_rd = mq.pop_front(); did = 1; end
                    else begin m_rd = 8'h00; m_unf = 1; end
                end
                if (wr_en) begin
                    if (old < DEPTH || did) mq.push_back(wr_data);
                    else m_ovf = 1;
                end
                if (!m_af && mq.size() > m_afthr)              m_af = 1;
                else if (m_af && did && mq.size() <= m_afthr)  m_af = 0;
            end
            m_ae = (mq.size() <= m_aethr);
        end
    end

    always @(posedge clk) begin
        #(CLK_PER/4);
        if (m_live && rst_n) begin
            chk("R2 level",        int'(level), mq.size());
            chk("R2 rd_data",      int'(rd_data), int'(m_rd));
            chk("R7 almost_full",  int'(almost_full), int'(m_af));
            chk("R9 almost_empty", int'(almost_empty), int'(m_ae));
            chk("R3 ovf_flag",     int'(ovf_flag), int'(m_ovf));
            chk("R4 unf_flag",     int'(unf_flag), int'(m_unf));
            chk("R5 err_flag",     int'(err_flag), int'(m_ovf | m_unf));
            chk("R12 tx_req",      int'(tx_req), int'(m_tx));
        end
    end

    task automatic step(input logic w, input logic [7:0] d, input logic r);
        wr_en = w; wr_data = d; rd_en = r;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic load_thr(input logic [5:0] a, input logic [5:0] e);
        af_thr_in = a; ae_thr_in = e; thr_load = 1'b1;
        @(negedge clk);
        thr_load = 1'b0;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        int lv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 err", int'(err_flag), 0);
        chk("R1 tx_req", int'(tx_req), 0);
        // R1 default almost-empty threshold 4
        for (int i = 0; i < 4; i++) step(1'b1, 8'(i + 1), 1'b0);
        chk("R1 ae at 4", int'(almost_empty), 1);
        step(1'b1, 8'd5, 1'b0);
        chk("R1 ae at 5", int'(almost_empty), 0);
        step(1'b0, 8'd0, 1'b1);
        chk("R2 first byte", int'(rd_data), 1);
        lv = int'(level);
        step(1'b1, 8'hA5, 1'b1);
        chk("R6 pair level", int'(level), lv);
        chk("R2 second byte", int'(rd_data), 2);
        // fill to full; default almost-full threshold 0x37
        for (int i = 0; i < 80 && level < 7'(DEPTH); i++) step(1'b1, 8'(i + 16), 1'b0);
        chk("R7 af when full", int'(almost_full), 1);
        step(1'b1, 8'hEE, 1'b0);
        chk("R3 level after drop", int'(level), DEPTH);
        chk("R3 ovf", int'(ovf_flag), 1);
        chk("R5 err", int'(err_flag), 1);
        step(1'b1, 8'h33, 1'b1);
        chk("R6 pair at full", int'(level), DEPTH);
        // drain to 56 then 55
        for (int i = 0; i < 20 && level > 7'd56; i++) step(1'b0, 8'd0, 1'b1);
        chk("R8 af at 56", int'(almost_full), 1);
        step(1'b0, 8'd0, 1'b1);
        chk("R8 af at 55", int'(almost_full), 0);
        step(1'b1, 8'h44, 1'b0);
        chk("R7 af at 56", int'(almost_full), 1);
        load_thr(6'd63, 6'd4);
        chk("R8 af after raise", int'(almost_full), 1);
        step(1'b0, 8'd0, 1'b1);
        chk("R8 af after read", int'(almost_full), 0);
        load_thr(6'd63, 6'd60);
        chk("R10 ae after load", int'(almost_empty), 1);
        // two-step clear
        lv = int'(level);
        clr_ctl = 1'b1;
        step(1'b0, 8'd0, 1'b0);
        step(1'b0, 8'd0, 1'b0);
        chk("R11 level while held", int'(level), lv);
        chk("R11 err while held", int'(err_flag), 1);
        clr_ctl = 1'b0;
        step(1'b1, 8'h77, 1'b0);
        chk("R11 level after release", int'(level), 0);
        chk("R11 err after release", int'(err_flag), 0);
        // underflow
        step(1'b0, 8'd0, 1'b1);
        chk("R4 rd_data zero", int'(rd_data), 0);
        chk("R4 unf", int'(unf_flag), 1);
        step(1'b1, 8'h5A, 1'b1);
        chk("R6 pair at empty", int'(level), 1);
        clr_ctl = 1'b1; step(1'b0, 8'd0, 1'b0);
        clr_ctl = 1'b0; step(1'b0, 8'd0, 1'b0);
        // automatic transmit request
        load_thr(6'd8, 6'd2);
        auto_en = 1'b1;
        for (int i = 0; i < 9; i++) step(1'b1, 8'(i + 100), 1'b0);
        chk("R12 tx before", int'(tx_req), 0);
        step(1'b0, 8'd0, 1'b0);
        chk("R12 tx raised", int'(tx_req), 1);
        for (int i = 0; i < 9; i++) step(1'b0, 8'd0, 1'b1);
        chk("R12 tx still", int'(tx_req), 1);
        step(1'b0, 8'd0, 1'b0);
        chk("R12 tx dropped", int'(tx_req), 0);
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit fillp;
            fillp    = ((i / 250) % 2) == 0;
            wr_en    = fillp ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            rd_en    = fillp ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
            wr_data  = 8'($urandom);
            thr_load = ($urandom % 61 == 0);
            af_thr_in = 6'($urandom);
            ae_thr_in = 6'($urandom);
            if ($urandom % 89 == 0) clr_ctl = ~clr_ctl;
            if ($urandom % 199 == 0) auto_en = ~auto_en;
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0; thr_load = 1'b0; clr_ctl = 1'b0;
        repeat (3) @(negedge clk);
        report();
    end
endmodule